// File: doc/BRIEF.md
# Register-Write Command Stream Executor

This block replays a list of register writes that software has placed in memory. Software sets an enable flag and loads a head pointer and a tail pointer through a small configuration port. Both pointers are dword indices into a memory. A write to the tail pointer while the engine is enabled and idle starts a run. The engine then fetches dwords from head toward tail over a single-outstanding memory read port. It decodes them as 8-byte instruction pairs and drives each resulting write onto a register write bus as an offset, data and byte-enable set.

There are two kinds of write. A direct pair carries one value, its byte enables and its target offset. An indexed pair carries a count and an offset, and the values that follow are all sent to that single offset. An indexed instruction with an odd total length carries one padding dword so that the next instruction stays aligned. An all-zero pair does nothing, so software may zero-fill the tail of the list freely. An unknown opcode halts the run and raises a sticky error flag.

Top module: `cmdq_exec`

## Requirements
- R1: After reset, `ctl_enable`, `ctl_busy` and `ctl_error` are 0, and neither `mem_req` nor `rw_valid` is asserted.
- R2: A pair whose second dword has bits 31:24 = 8'h01 is a direct write. It causes exactly one bus write with data = first dword, byte enables = bits 23:20 of the second dword, and offset = bits 19:0 of the second dword.
- R3: A pair whose second dword has bits 31:24 = 8'h09 is an indexed write. The first dword holds a count N. The next N dwords are each written, in order, to the offset in bits 19:0 with byte enables 4'hF. Bits 23:20 of the indexed second dword have no effect.
- R4: When 2+N is odd, the dword after the last value is padding. It is never written, and the next instruction is fetched from the next even dword index. When 2+N is even, the next instruction follows at once.
- R5: An indexed write with N = 0 issues no bus write, and execution continues with the following pair.
- R6: A pair whose second dword has bits 31:24 = 8'h00 issues no write, and execution continues.
- R7: Any other opcode sets `ctl_error` and ends the run, with busy dropping and no further writes. The error stays set until a control write with bit 1 = 1 is made while idle.
- R8: Configuration addresses are 0 = control (bit 0 enable, bit 1 error clear), 1 = head and 2 = tail. Bit 0 of a pointer is forced to 0. A tail write starts a run only if enable is 1, busy is 0 and the new tail differs from head.
- R9: `ctl_busy` stays 1 from the start until the fetch position equals tail at an instruction boundary. The head register is not changed by a run.
- R10: While busy, writes to control, head and tail have no effect. Enable stays set, a later run starts from the old head, and a tail write does not start another run.
- R11: At most one memory read is outstanding. Fetch addresses run upward from head, one dword per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | PTR_W | Configuration write data |
| ctl_enable | output | 1 | Enable flag |
| ctl_busy | output | 1 | Run in progress |
| ctl_error | output | 1 | Sticky bad-opcode flag |
| mem_req | output | 1 | Memory read request, one cycle |
| mem_addr | output | PTR_W | Dword index being read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| rw_valid | output | 1 | Register write strobe |
| rw_addr | output | 20 | Register offset |
| rw_data | output | 32 | Register write data |
| rw_be | output | 4 | Byte enables |

## Verification
The checks assume that the memory returns exactly one `mem_rvalid` for each `mem_req`, and never one without a request. They also assume that instruction lists are well formed: every run begins at an even index, and tail lands on an instruction boundary. The bench memory model answers every request on the following cycle and on no other. Every list it loads uses even head and tail values placed at pair boundaries, so the stimulus stays within these assumptions. Configuration writes made during a run are issued deliberately, to show that they are ignored.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned OFF_W  = 20;
    localparam int unsigned BE_W   = 4;
    localparam int unsigned OP_W   = 8;
    localparam int unsigned OP_LSB = WORD_W - OP_W;
    localparam int unsigned BE_LSB = OFF_W;

    localparam logic [OP_W-1:0] OP_NOP    = 8'h00;
    localparam logic [OP_W-1:0] OP_DIRECT = 8'h01;
    localparam logic [OP_W-1:0] OP_INDEX  = 8'h09;

    localparam logic [1:0] CFG_CTRL = 2'd0;
    localparam logic [1:0] CFG_HEAD = 2'd1;
    localparam logic [1:0] CFG_TAIL = 2'd2;

    typedef enum logic [1:0] {K_NOP, K_DIRECT, K_INDEX, K_BAD} kind_e;

    typedef enum logic [3:0] {
        S_IDLE, S_CHK, S_REQ0, S_WAIT0, S_REQ1, S_WAIT1,
        S_EXEC, S_DREQ, S_DWAIT, S_WR
    } state_e;
endpackage

// File: rtl/cmdq_decode.sv
module cmdq_decode
    import cmdq_pkg::*;
(
    input  logic [WORD_W-1:0] ctl_word,
    output kind_e             kind,
    output logic [OFF_W-1:0]  offset,
    output logic [BE_W-1:0]   bytes
);
    logic [OP_W-1:0] opcode;

    always_comb begin
        opcode = ctl_word[WORD_W-1:OP_LSB];
        offset = ctl_word[OFF_W-1:0];
        bytes  = ctl_word[BE_LSB+BE_W-1:BE_LSB];
        case (opcode)
            OP_NOP:    kind = K_NOP;
            OP_DIRECT: kind = K_DIRECT;
            OP_INDEX: begin
                kind  = K_INDEX;
                bytes = '1;        // indexed writes always use all byte lanes
            end
            default:   kind = K_BAD;
        endcase
    end
endmodule

// File: rtl/cmdq_cfg.sv
module cmdq_cfg
    import cmdq_pkg::*;
#(
    parameter int unsigned PTR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [PTR_W-1:0] wdata,
    input  logic             busy,
    input  logic             err_set,
    output logic             enable,
    output logic             error,
    output logic [PTR_W-1:0] head,
    output logic [PTR_W-1:0] tail,
    output logic             start
);
    typedef struct packed {
        logic             enable;
        logic             error;
        logic [PTR_W-1:0] head;
        logic [PTR_W-1:0] tail;
    } cfg_t;

    cfg_t             cfg_d, cfg_q;
    logic [PTR_W-1:0] ptr_aligned;

    always_comb begin
        cfg_d       = cfg_q;
        start       = 1'b0;
        ptr_aligned = {wdata[PTR_W-1:1], 1'b0};
        if (err_set) begin
            cfg_d.error = 1'b1;
        end
        if (wr_en && !busy) begin
            case (addr)
                CFG_CTRL: begin
                    cfg_d.enable = wdata[0];
                    if (wdata[1]) begin
                        cfg_d.error = 1'b0;
                    end
                end
                CFG_HEAD: cfg_d.head = ptr_aligned;
                CFG_TAIL: begin
                    cfg_d.tail = ptr_aligned;
                    start      = cfg_q.enable && (ptr_aligned != cfg_q.head);
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign enable = cfg_q.enable;
    assign error  = cfg_q.error;
    assign head   = cfg_q.head;
    assign tail   = cfg_q.tail;
endmodule

// File: rtl/cmdq_seq.sv
module cmdq_seq
    import cmdq_pkg::*;
#(
    parameter int unsigned PTR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [PTR_W-1:0]  head,
    input  logic [PTR_W-1:0]  tail,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    input  kind_e             kind,
    input  logic [OFF_W-1:0]  offset,
    input  logic [BE_W-1:0]   bytes,
    output logic [WORD_W-1:0] ctl_word,
    output logic              busy,
    output logic              err_set,
    output logic              mem_req,
    output logic [PTR_W-1:0]  mem_addr,
    output logic              rw_valid,
    output logic [OFF_W-1:0]  rw_addr,
    output logic [WORD_W-1:0] rw_data,
    output logic [BE_W-1:0]   rw_be
);
    localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

    typedef struct packed {
        state_e            st;
        logic [PTR_W-1:0]  cur;
        logic [PTR_W-1:0]  left;
        logic              burst;
        logic [WORD_W-1:0] dw0;
        logic [WORD_W-1:0] dw1;
        logic [OFF_W-1:0]  wr_addr;
        logic [WORD_W-1:0] wr_data;
        logic [BE_W-1:0]   wr_be;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d    = seq_q;
        mem_req  = 1'b0;
        err_set  = 1'b0;
        rw_valid = 1'b0;
        case (seq_q.st)
            S_IDLE: begin
                if (start) begin
                    seq_d.st  = S_CHK;
                    seq_d.cur = head;
                end
            end
            S_CHK: seq_d.st = (seq_q.cur == tail) ? S_IDLE : S_REQ0;
            S_REQ0: begin
                mem_req  = 1'b1;
                seq_d.st = S_WAIT0;
            end
            S_WAIT0: begin
                if (mem_rvalid) begin
                    seq_d.dw0 = mem_rdata;
                    seq_d.cur = seq_q.cur + ONE;
                    seq_d.st  = S_REQ1;
                end
            end
            S_REQ1: begin
                mem_req  = 1'b1;
                seq_d.st = S_WAIT1;
            end
            S_WAIT1: begin
                if (mem_rvalid) begin
                    seq_d.dw1 = mem_rdata;
                    seq_d.cur = seq_q.cur + ONE;
                    seq_d.st  = S_EXEC;
                end
            end
            S_EXEC: begin
                seq_d.burst   = 1'b0;
                seq_d.wr_addr = offset;
                seq_d.wr_be   = bytes;
                case (kind)
                    K_DIRECT: begin
                        seq_d.wr_data = seq_q.dw0;
                        seq_d.st      = S_WR;
                    end
                    K_INDEX: begin
                        seq_d.burst = 1'b1;
                        seq_d.left  = seq_q.dw0[PTR_W-1:0];
                        seq_d.st    = (seq_q.dw0[PTR_W-1:0] == '0) ? S_CHK : S_DREQ;
                    end
                    K_NOP:   seq_d.st = S_CHK;
                    default: begin
                        err_set  = 1'b1;
                        seq_d.st = S_IDLE;
                    end
                endcase
            end
            S_DREQ: begin
                mem_req  = 1'b1;
                seq_d.st = S_DWAIT;
            end
            S_DWAIT: begin
                if (mem_rvalid) begin
                    seq_d.wr_data = mem_rdata;
                    seq_d.cur     = seq_q.cur + ONE;
                    seq_d.left    = seq_q.left - ONE;
                    seq_d.st      = S_WR;
                end
            end
            S_WR: begin
                rw_valid = 1'b1;
                if (seq_q.burst && (seq_q.left != '0)) begin
                    seq_d.st = S_DREQ;
                end else begin
                    seq_d.st = S_CHK;
                    if (seq_q.burst) begin
                        // step over the padding dword of an odd-length burst
                        seq_d.cur = seq_q.cur + {{(PTR_W-1){1'b0}}, seq_q.cur[0]};
                    end
                end
            end
            default: seq_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy     = (seq_q.st != S_IDLE);
    assign mem_addr = seq_q.cur;
    assign ctl_word = seq_q.dw1;
    assign rw_addr  = seq_q.wr_addr;
    assign rw_data  = seq_q.wr_data;
    assign rw_be    = seq_q.wr_be;
endmodule

// File: rtl/cmdq_exec.sv
module cmdq_exec
    import cmdq_pkg::*;
#(
    parameter int unsigned PTR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [1:0]        cfg_addr,
    input  logic [PTR_W-1:0]  cfg_wdata,
    output logic              ctl_enable,
    output logic              ctl_busy,
    output logic              ctl_error,
    output logic              mem_req,
    output logic [PTR_W-1:0]  mem_addr,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              rw_valid,
    output logic [OFF_W-1:0]  rw_addr,
    output logic [WORD_W-1:0] rw_data,
    output logic [BE_W-1:0]   rw_be
);
    logic              start;
    logic              err_set;
    logic [PTR_W-1:0]  head;
    logic [PTR_W-1:0]  tail;
    logic [WORD_W-1:0] ctl_word;
    kind_e             kind;
    logic [OFF_W-1:0]  offset;
    logic [BE_W-1:0]   bytes;

    cmdq_cfg #(.PTR_W(PTR_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .addr    (cfg_addr),
        .wdata   (cfg_wdata),
        .busy    (ctl_busy),
        .err_set (err_set),
        .enable  (ctl_enable),
        .error   (ctl_error),
        .head    (head),
        .tail    (tail),
        .start   (start)
    );

    cmdq_decode u_dec (
        .ctl_word (ctl_word),
        .kind     (kind),
        .offset   (offset),
        .bytes    (bytes)
    );

    cmdq_seq #(.PTR_W(PTR_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .head       (head),
        .tail       (tail),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .kind       (kind),
        .offset     (offset),
        .bytes      (bytes),
        .ctl_word   (ctl_word),
        .busy       (ctl_busy),
        .err_set    (err_set),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .rw_valid   (rw_valid),
        .rw_addr    (rw_addr),
        .rw_data    (rw_data),
        .rw_be      (rw_be)
    );
endmodule

// File: rtl/cmdq_exec_chk.sv
module cmdq_exec_chk #(
    parameter int unsigned PTR_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_wr_en,
    input logic [1:0]       cfg_addr,
    input logic             ctl_enable,
    input logic             ctl_busy,
    input logic             ctl_error,
    input logic             mem_req,
    input logic [PTR_W-1:0] mem_addr,
    input logic             mem_rvalid,
    input logic             rw_valid
);
    logic pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (mem_req) begin
            pend_q <= 1'b1;
        end else if (mem_rvalid) begin
            pend_q <= 1'b0;
        end
    end

    // R11: never a second request while one is in flight
    assert_one_outstanding_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !pend_q);

    // R11: fetch address holds while the read is outstanding
    assert_addr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q && !mem_rvalid |-> $stable(mem_addr));

    // R9 / R1: no activity outside a run
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_busy |-> !mem_req && !rw_valid);

    // R10: control write during a run leaves enable unchanged
    assert_ctrl_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_busy && cfg_wr_en && cfg_addr == 2'd0 |=> $stable(ctl_enable));

    // R10: a run never exists without enable
    assert_busy_enabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_busy |-> ctl_enable);

    // R7: error rises exactly as the run ends
    assert_err_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_error) |-> !ctl_busy && $past(ctl_busy));
endmodule

bind cmdq_exec cmdq_exec_chk #(.PTR_W(PTR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr_en  (cfg_wr_en),
    .cfg_addr   (cfg_addr),
    .ctl_enable (ctl_enable),
    .ctl_busy   (ctl_busy),
    .ctl_error  (ctl_error),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .rw_valid   (rw_valid)
);

// File: tb/cmdq_exec_tb.sv
module cmdq_exec_tb;
    localparam int CLK_PERIOD = 10;
    localparam int PTR_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_wr_en = 1'b0;
    logic [1:0]       cfg_addr = 2'd0;
    logic [PTR_W-1:0] cfg_wdata = '0;
    logic             ctl_enable, ctl_busy, ctl_error;
    logic             mem_req;
    logic [PTR_W-1:0] mem_addr;
    logic             mem_rvalid = 1'b0;
    logic [31:0]      mem_rdata = '0;
    logic             rw_valid;
    logic [19:0]      rw_addr;
    logic [31:0]      rw_data;
    logic [3:0]       rw_be;

    logic [31:0] mem [128];
    logic [19:0] log_a [256];
    logic [31:0] log_d [256];
    logic [3:0]  log_b [256];
    int          lcnt = 0;
    int          checks = 0;
    int          failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmdq_exec #(.PTR_W(PTR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .ctl_enable(ctl_enable), .ctl_busy(ctl_busy),
        .ctl_error(ctl_error), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .rw_valid(rw_valid),
        .rw_addr(rw_addr), .rw_data(rw_data), .rw_be(rw_be)
    );

    // memory model: answers every request on the next cycle
    always @(posedge clk) begin
        mem_rvalid <= mem_req;
        mem_rdata  <= mem[mem_addr[6:0]];
    end

    always @(posedge clk) begin
        if (rw_valid && lcnt < 256) begin
            log_a[lcnt] <= rw_addr;
            log_d[lcnt] <= rw_data;
            log_b[lcnt] <= rw_be;
            lcnt <= lcnt + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] a, input logic [PTR_W-1:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1;
        cfg_addr  = a;
        cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (ctl_busy && n < 2000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic run(input int h, input int t);
        cfg_write(2'd1, PTR_W'(h));
        cfg_write(2'd2, PTR_W'(t));
        wait_idle();
        repeat (2) @(negedge clk);
    endtask

    task automatic expw(input string req, input int idx, input logic [19:0] a,
                        input logic [31:0] d, input logic [3:0] b);
        chk(req, 32'(log_a[idx]), 32'(a), "write offset");
        chk(req, log_d[idx], d, "write data");
        chk(req, 32'(log_b[idx]), 32'(b), "write byte enables");
    endtask

    task automatic t_reset();
        chk("R1", 32'(ctl_enable), 0, "enable after reset");
        chk("R1", 32'(ctl_busy), 0, "busy after reset");
        chk("R1", 32'(ctl_error), 0, "error after reset");
        chk("R1", 32'(mem_req | rw_valid), 0, "bus quiet after reset");
    endtask

    task automatic t_direct();
        int base = lcnt;
        mem[0] = 32'hDEADBEEF; mem[1] = {8'h01, 4'h5, 20'h12345};
        mem[2] = 32'h11112222; mem[3] = {8'h01, 4'hF, 20'h00ABC};
        run(0, 4);
        chk("R2", 32'(lcnt - base), 2, "direct write count");
        expw("R2", base, 20'h12345, 32'hDEADBEEF, 4'h5);
        expw("R2", base + 1, 20'h00ABC, 32'h11112222, 4'hF);
        chk("R9", 32'(ctl_busy), 0, "busy cleared at tail");
    endtask

    task automatic t_index_odd();
        int base = lcnt;
        mem[16] = 3; mem[17] = {8'h09, 4'h2, 20'h00400};
        mem[18] = 32'hA; mem[19] = 32'hB; mem[20] = 32'hC; mem[21] = 0;
        mem[22] = 32'h55; mem[23] = {8'h01, 4'hF, 20'h00777};
        run(16, 24);
        chk("R4", 32'(lcnt - base), 4, "odd burst plus direct count");
        expw("R3", base, 20'h00400, 32'hA, 4'hF);
        expw("R3", base + 1, 20'h00400, 32'hB, 4'hF);
        expw("R3", base + 2, 20'h00400, 32'hC, 4'hF);
        expw("R4", base + 3, 20'h00777, 32'h55, 4'hF);
    endtask

    task automatic t_index_even();
        int base = lcnt;
        mem[32] = 2; mem[33] = {8'h09, 4'h0, 20'h00500};
        mem[34] = 32'h1; mem[35] = 32'h2;
        mem[36] = 32'h99; mem[37] = {8'h01, 4'h3, 20'h00600};
        run(32, 38);
        chk("R4", 32'(lcnt - base), 3, "even burst count");
        expw("R3", base + 1, 20'h00500, 32'h2, 4'hF);
        expw("R4", base + 2, 20'h00600, 32'h99, 4'h3);
    endtask

    task automatic t_zero_nop();
        int base = lcnt;
        mem[40] = 0; mem[41] = {8'h09, 4'h0, 20'h00800};
        mem[42] = 0; mem[43] = 0;
        mem[44] = 32'h77; mem[45] = {8'h01, 4'hF, 20'h00900};
        run(40, 46);
        chk("R5", 32'(lcnt - base), 1, "zero count and no-op give one write");
        expw("R6", base, 20'h00900, 32'h77, 4'hF);
    endtask

    task automatic t_error();
        int base = lcnt;
        mem[48] = 5; mem[49] = {8'h42, 4'hF, 20'h00100};
        mem[50] = 32'h66; mem[51] = {8'h01, 4'hF, 20'h00200};
        run(48, 52);
        chk("R7", 32'(lcnt - base), 0, "no writes after bad opcode");
        chk("R7", 32'(ctl_error), 1, "error set");
        chk("R7", 32'(ctl_busy), 0, "busy cleared on error");
        cfg_write(2'd0, 16'h0001);
        chk("R7", 32'(ctl_error), 1, "error sticky without clear bit");
        cfg_write(2'd0, 16'h0003);
        chk("R7", 32'(ctl_error), 0, "error cleared");
        chk("R8", 32'(ctl_enable), 1, "enable kept");
    endtask

    task automatic t_no_start();
        int base = lcnt;
        cfg_write(2'd0, 16'h0000);
        cfg_write(2'd1, 16'd0);
        cfg_write(2'd2, 16'd4);
        chk("R8", 32'(ctl_busy), 0, "no start while disabled");
        cfg_write(2'd0, 16'h0001);
        cfg_write(2'd2, 16'd0);
        chk("R8", 32'(ctl_busy), 0, "no start when tail equals head");
        repeat (10) @(negedge clk);
        chk("R8", 32'(lcnt - base), 0, "no writes without start");
    endtask

    task automatic t_busy_ignore();
        int base = lcnt;
        mem[64] = 20; mem[65] = {8'h09, 4'h0, 20'h00A00};
        for (int i = 0; i < 20; i++) mem[66 + i] = 32'h100 + 32'(i);
        cfg_write(2'd1, 16'd64);
        cfg_write(2'd2, 16'd86);
        cfg_write(2'd0, 16'h0000);
        cfg_write(2'd1, 16'd0);
        cfg_write(2'd2, 16'd4);
        chk("R10", 32'(ctl_enable), 1, "enable held while busy");
        chk("R9", 32'(ctl_busy), 1, "busy during run");
        wait_idle();
        repeat (6) @(negedge clk);
        chk("R10", 32'(ctl_busy), 0, "tail write during run did not restart");
        chk("R10", 32'(lcnt - base), 20, "burst length");
        expw("R10", base + 19, 20'h00A00, 32'h113, 4'hF);
        base = lcnt;
        cfg_write(2'd2, 16'd86);
        chk("R10", 32'(ctl_busy), 1, "rerun did not start");
        wait_idle();
        repeat (2) @(negedge clk);
        chk("R9", 32'(lcnt - base), 20, "rerun from unchanged head");
        expw("R9", base, 20'h00A00, 32'h100, 4'hF);
    endtask

    initial begin
        for (int i = 0; i < 128; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        cfg_write(2'd0, 16'h0001);
        t_direct();
        t_index_odd();
        t_index_even();
        t_zero_nop();
        t_error();
        t_no_start();
        t_busy_ignore();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog R9 actual=hung expected=idle");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule